// File: doc/BRIEF.md
# Two-Bank Synchronous Burst Memory

A clocked memory model that holds two independent banks, each able to keep one row open at the same time. A command word selects one of six operations each clock: idle, mode load, row open, read, write and row close. Reads and writes name only a starting column. An on-chip counter then walks the rest of the burst, one data word per clock, with no further addresses needed.

Burst length and read latency are set at run time by a mode-load cycle that uses the address lines as its operand. While one bank is moving burst data, the other bank may be opened or closed, so the next access can be prepared before the current one ends. Commands that cannot be honoured are dropped and reported on a one-cycle error pulse. Array sizes are parameters, kept small for simulation.

Top module: `dual_bank_burst_ram`

## Requirements
- R1: After reset, the burst length is 1 and the read latency is 2, both banks are closed, and `rd_valid_o`, `rd_data_o` and `err_o` are all zero.
- R2: A mode load (command code 1) takes `addr_i[1:0]` as the burst length code and `addr_i[2]` as the latency select. The length codes 0, 1, 2 and 3 give 1, 2, 4 and 8 words. Latency select 0 gives 2 cycles and 1 gives 3 cycles. Higher address bits are ignored.
- R3: A read (code 3) issued in cycle c with latency L and burst length B drives `rd_valid_o` high in cycles c+L through c+L+B-1 and nowhere else. While `rd_valid_o` is low, `rd_data_o` is zero.
- R4: Burst columns step upward from the start column and wrap inside the aligned block of B columns. Column i of the burst is (start & ~(B-1)) | ((start+i) & (B-1)).
- R5: A write (code 4) issued in cycle c stores `wr_data_i` from cycles c through c+B-1 into the burst columns, in the same order as R4.
- R6: An activate (code 2) opens row `addr_i[ROW_W-1:0]` in the bank chosen by `bank_i`. Both banks can hold open rows at the same time, and reads and writes use the row that is open in the selected bank.
- R7: A read or write to a closed bank is dropped: it moves no data and raises `err_o` in cycle c+1. An idle command (code 0) never raises `err_o`.
- R8: A precharge (code 5) closes the selected bank, and closing a bank that is already closed raises no error. An activate to an open bank is dropped with `err_o` in cycle c+1, and the bank keeps its old row.
- R9: While a burst is in progress, any read, write or mode load is dropped with `err_o` in cycle c+1, and so is a precharge of the bursting bank. An activate or precharge of the other bank is accepted. A read is in progress from cycle c+1 through c+L+B-2. A write is in progress from cycle c+1 through c+B-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Synchronous reset, active low |
| cmd_i | input | 3 | Command: 0 idle, 1 mode load, 2 activate, 3 read, 4 write, 5 precharge |
| bank_i | input | BANK_W (1) | Bank select |
| addr_i | input | ADDR_W (4) | Row for activate, start column for read or write, operand for mode load |
| wr_data_i | input | DATA_W (16) | Write burst data, one word per cycle |
| rd_data_o | output | DATA_W (16) | Read burst data, zero when not valid |
| rd_valid_o | output | 1 | Read data valid |
| err_o | output | 1 | Pulse one cycle after a dropped command |

## Verification
For a read in cycle c, the first word is due in cycle c+L and the last in cycle c+L+B-1. An error pulse is due in cycle c+1, and write words are consumed in cycles c to c+B-1. The bench keeps a reference model that, when a command is issued, writes the expected valid, data and error values into a slot ring indexed by the cycle in which they are due. Every cycle it compares all three outputs with the slot for that cycle, sampling on the falling edge. Cycles with no expectation are therefore checked for silence: no valid, zero data and no error.

// File: rtl/dbbr_pkg.sv
package dbbr_pkg;
   typedef enum logic [2:0] {
      CMD_NOP  = 3'd0,
      CMD_MODE = 3'd1,
      CMD_ACT  = 3'd2,
      CMD_RD   = 3'd3,
      CMD_WR   = 3'd4,
      CMD_PRE  = 3'd5
   } cmd_e;

   localparam int unsigned MAX_BURST   = 8;
   localparam int unsigned BURST_CNT_W = 3;
endpackage

// File: rtl/dbbr_mode_reg.sv
module dbbr_mode_reg (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       load_i,
   input  logic [2:0] code_i,
   output logic [2:0] blm1_o,
   output logic       lat3_o
);
   logic [1:0] len_code_q;
   logic       lat_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         len_code_q <= 2'd0;
         lat_q      <= 1'b0;
      end else if (load_i) begin
         len_code_q <= code_i[1:0];
         lat_q      <= code_i[2];
      end
   end

   // burst length minus one: 1,2,4,8 words
   always_comb begin
      case (len_code_q)
         2'd0:    blm1_o = 3'd0;
         2'd1:    blm1_o = 3'd1;
         2'd2:    blm1_o = 3'd3;
         default: blm1_o = 3'd7;
      endcase
   end

   assign lat3_o = lat_q;
endmodule

// File: rtl/dbbr_bank.sv
module dbbr_bank #(
   parameter int unsigned ROW_W  = 3,
   parameter int unsigned COL_W  = 4,
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              act_i,
   input  logic              pre_i,
   input  logic [ROW_W-1:0]  act_row_i,
   input  logic              we_i,
   input  logic [ROW_W-1:0]  wr_row_i,
   input  logic [COL_W-1:0]  wr_col_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [ROW_W-1:0]  rd_row_i,
   input  logic [COL_W-1:0]  rd_col_i,
   output logic              open_o,
   output logic [ROW_W-1:0]  row_o,
   output logic [DATA_W-1:0] rd_data_o
);
   localparam int unsigned WORDS = 1 << (ROW_W + COL_W);

   logic [DATA_W-1:0] cells_q [WORDS];
   logic              open_q;
   logic [ROW_W-1:0]  row_q;

   always_ff @(posedge clk_i) begin
      if (we_i) cells_q[{wr_row_i, wr_col_i}] <= wr_data_i;
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         open_q <= 1'b0;
         row_q  <= '0;
      end else if (pre_i) begin
         open_q <= 1'b0;
      end else if (act_i) begin
         open_q <= 1'b1;
         row_q  <= act_row_i;
      end
   end

   assign open_o    = open_q;
   assign row_o     = row_q;
   assign rd_data_o = cells_q[{rd_row_i, rd_col_i}];
endmodule

// File: rtl/dbbr_burst_engine.sv
module dbbr_burst_engine #(
   parameter int unsigned BANK_W = 1,
   parameter int unsigned ROW_W  = 3,
   parameter int unsigned COL_W  = 4,
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_rd_i,
   input  logic              start_wr_i,
   input  logic [BANK_W-1:0] bank_i,
   input  logic [ROW_W-1:0]  row_i,
   input  logic [COL_W-1:0]  col_i,
   input  logic [2:0]        blm1_i,
   input  logic              lat3_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [DATA_W-1:0] rd_word_i,
   output logic              busy_o,
   output logic [BANK_W-1:0] bank_o,
   output logic              we_o,
   output logic [BANK_W-1:0] we_bank_o,
   output logic [ROW_W-1:0]  we_row_o,
   output logic [COL_W-1:0]  we_col_o,
   output logic [DATA_W-1:0] we_data_o,
   output logic [ROW_W-1:0]  rd_row_o,
   output logic [COL_W-1:0]  rd_col_o,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              rd_valid_o
);
   logic              active_q;
   logic              is_wr_q;
   logic              wait_q;
   logic [2:0]        cnt_q;
   logic [2:0]        idx_q;
   logic [2:0]        mask_q;
   logic [COL_W-1:0]  base_q;
   logic [BANK_W-1:0] bank_q;
   logic [ROW_W-1:0]  row_q;
   logic [DATA_W-1:0] rd_data_q;
   logic              rd_valid_q;

   logic [COL_W-1:0]  mask_ext;
   logic [COL_W-1:0]  step_col;

   // column counter wraps inside the aligned burst block
   assign mask_ext = COL_W'(mask_q);
   assign step_col = (base_q & ~mask_ext) | ((base_q + COL_W'(idx_q)) & mask_ext);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         active_q   <= 1'b0;
         is_wr_q    <= 1'b0;
         wait_q     <= 1'b0;
         cnt_q      <= '0;
         idx_q      <= '0;
         mask_q     <= '0;
         base_q     <= '0;
         bank_q     <= '0;
         row_q      <= '0;
         rd_data_q  <= '0;
         rd_valid_q <= 1'b0;
      end else begin
         rd_valid_q <= 1'b0;
         rd_data_q  <= '0;
         if (start_rd_i) begin
            active_q <= 1'b1;
            is_wr_q  <= 1'b0;
            wait_q   <= lat3_i;
            cnt_q    <= blm1_i;
            idx_q    <= 3'd0;
            mask_q   <= blm1_i;
            base_q   <= col_i;
            bank_q   <= bank_i;
            row_q    <= row_i;
         end else if (start_wr_i) begin
            // first word is stored in the command cycle itself
            active_q <= (blm1_i != 3'd0);
            is_wr_q  <= 1'b1;
            wait_q   <= 1'b0;
            cnt_q    <= blm1_i - 3'd1;
            idx_q    <= 3'd1;
            mask_q   <= blm1_i;
            base_q   <= col_i;
            bank_q   <= bank_i;
            row_q    <= row_i;
         end else if (active_q) begin
            if (!is_wr_q && wait_q) begin
               wait_q <= 1'b0;
            end else begin
               if (!is_wr_q) begin
                  rd_valid_q <= 1'b1;
                  rd_data_q  <= rd_word_i;
               end
               idx_q <= idx_q + 3'd1;
               if (cnt_q == 3'd0) active_q <= 1'b0;
               else               cnt_q    <= cnt_q - 3'd1;
            end
         end
      end
   end

   always_comb begin
      if (start_wr_i) begin
         we_o      = 1'b1;
         we_bank_o = bank_i;
         we_row_o  = row_i;
         we_col_o  = col_i;
      end else begin
         we_o      = active_q && is_wr_q;
         we_bank_o = bank_q;
         we_row_o  = row_q;
         we_col_o  = step_col;
      end
   end

   assign we_data_o  = wr_data_i;
   assign busy_o     = active_q;
   assign bank_o     = bank_q;
   assign rd_row_o   = row_q;
   assign rd_col_o   = step_col;
   assign rd_data_o  = rd_data_q;
   assign rd_valid_o = rd_valid_q;
endmodule

// File: rtl/dual_bank_burst_ram.sv
module dual_bank_burst_ram
   import dbbr_pkg::*;
#(
   parameter int unsigned NUM_BANKS = 2,
   parameter int unsigned ROW_W     = 3,
   parameter int unsigned COL_W     = 4,
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned ADDR_W    = 4,
   localparam int unsigned BANK_W   = $clog2(NUM_BANKS)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [2:0]        cmd_i,
   input  logic [BANK_W-1:0] bank_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              rd_valid_o,
   output logic              err_o
);
   // elaboration-time parameter checks
   if (NUM_BANKS < 2 || (NUM_BANKS & (NUM_BANKS - 1)) != 0) begin : g_bad_banks
      $error("NUM_BANKS must be a power of two, at least 2");
   end
   if (COL_W < BURST_CNT_W) begin : g_bad_col
      $error("COL_W must hold the longest burst");
   end
   if (ADDR_W < ROW_W || ADDR_W < COL_W || ADDR_W < 3) begin : g_bad_addr
      $error("ADDR_W too narrow for row, column or mode operand");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be positive");
   end

   logic [NUM_BANKS-1:0] bank_open;
   logic [ROW_W-1:0]     bank_row [NUM_BANKS];
   logic [DATA_W-1:0]    bank_rd  [NUM_BANKS];

   logic [2:0]        blm1;
   logic              lat3;
   logic              eng_busy;
   logic [BANK_W-1:0] eng_bank;
   logic              eng_we;
   logic [BANK_W-1:0] eng_we_bank;
   logic [ROW_W-1:0]  eng_we_row;
   logic [COL_W-1:0]  eng_we_col;
   logic [DATA_W-1:0] eng_we_data;
   logic [ROW_W-1:0]  eng_rd_row;
   logic [COL_W-1:0]  eng_rd_col;

   logic is_mode, is_act, is_rd, is_wr, is_pre;
   logic sel_open;
   logic acc_mode, acc_act, acc_rd, acc_wr, acc_pre;
   logic reject;
   logic err_q;

   assign is_mode = (cmd_i == CMD_MODE);
   assign is_act  = (cmd_i == CMD_ACT);
   assign is_rd   = (cmd_i == CMD_RD);
   assign is_wr   = (cmd_i == CMD_WR);
   assign is_pre  = (cmd_i == CMD_PRE);

   assign sel_open = bank_open[bank_i];

   // acceptance rules; a burst in flight blocks new transfers and mode changes
   assign acc_mode = is_mode && !eng_busy;
   assign acc_act  = is_act  && !sel_open;
   assign acc_pre  = is_pre  && !(eng_busy && (eng_bank == bank_i));
   assign acc_rd   = is_rd   && !eng_busy && sel_open;
   assign acc_wr   = is_wr   && !eng_busy && sel_open;

   assign reject = (is_mode && !acc_mode) || (is_act && !acc_act) ||
                   (is_pre && !acc_pre)   || (is_rd && !acc_rd)   ||
                   (is_wr && !acc_wr);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) err_q <= 1'b0;
      else         err_q <= reject;
   end

   dbbr_mode_reg u_mode (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (acc_mode),
      .code_i (addr_i[2:0]),
      .blm1_o (blm1),
      .lat3_o (lat3)
   );

   for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
      dbbr_bank #(
         .ROW_W  (ROW_W),
         .COL_W  (COL_W),
         .DATA_W (DATA_W)
      ) u_bank (
         .clk_i     (clk_i),
         .rst_ni    (rst_ni),
         .act_i     (acc_act && (bank_i == BANK_W'(g))),
         .pre_i     (acc_pre && (bank_i == BANK_W'(g))),
         .act_row_i (addr_i[ROW_W-1:0]),
         .we_i      (eng_we && (eng_we_bank == BANK_W'(g))),
         .wr_row_i  (eng_we_row),
         .wr_col_i  (eng_we_col),
         .wr_data_i (eng_we_data),
         .rd_row_i  (eng_rd_row),
         .rd_col_i  (eng_rd_col),
         .open_o    (bank_open[g]),
         .row_o     (bank_row[g]),
         .rd_data_o (bank_rd[g])
      );
   end

   dbbr_burst_engine #(
      .BANK_W (BANK_W),
      .ROW_W  (ROW_W),
      .COL_W  (COL_W),
      .DATA_W (DATA_W)
   ) u_engine (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .start_rd_i (acc_rd),
      .start_wr_i (acc_wr),
      .bank_i     (bank_i),
      .row_i      (bank_row[bank_i]),
      .col_i      (addr_i[COL_W-1:0]),
      .blm1_i     (blm1),
      .lat3_i     (lat3),
      .wr_data_i  (wr_data_i),
      .rd_word_i  (bank_rd[eng_bank]),
      .busy_o     (eng_busy),
      .bank_o     (eng_bank),
      .we_o       (eng_we),
      .we_bank_o  (eng_we_bank),
      .we_row_o   (eng_we_row),
      .we_col_o   (eng_we_col),
      .we_data_o  (eng_we_data),
      .rd_row_o   (eng_rd_row),
      .rd_col_o   (eng_rd_col),
      .rd_data_o  (rd_data_o),
      .rd_valid_o (rd_valid_o)
   );

   assign err_o = err_q;
endmodule

// File: rtl/dual_bank_burst_ram_chk.sv
module dual_bank_burst_ram_chk
   import dbbr_pkg::*;
#(
   parameter int unsigned NUM_BANKS = 2,
   parameter int unsigned DATA_W    = 16,
   localparam int unsigned BANK_W   = $clog2(NUM_BANKS)
) (
   input logic                 clk_i,
   input logic                 rst_ni,
   input logic [2:0]           cmd_i,
   input logic [BANK_W-1:0]    bank_i,
   input logic [DATA_W-1:0]    rd_data_o,
   input logic                 rd_valid_o,
   input logic                 err_o,
   input logic [NUM_BANKS-1:0] open_vec,
   input logic                 eng_busy,
   input logic [BANK_W-1:0]    eng_bank
);
   logic [1:0] since_rst_q;
   logic [3:0] run_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         since_rst_q <= 2'd0;
         run_q       <= 4'd0;
      end else begin
         if (since_rst_q != 2'd3) since_rst_q <= since_rst_q + 2'd1;
         if (rd_valid_o) run_q <= (run_q == 4'd15) ? run_q : run_q + 4'd1;
         else            run_q <= 4'd0;
      end
   end

   // R1: no read data can appear before the shortest latency has passed
   assert_quiet_after_reset_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (since_rst_q < 2'd2) |-> (!rd_valid_o && !err_o || since_rst_q == 2'd1 && !rd_valid_o));

   assert_idle_data_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rd_valid_o |-> (rd_data_o == '0));

   assert_burst_run_max_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_q <= 4'd8);

   assert_closed_bank_err_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((cmd_i == CMD_RD || cmd_i == CMD_WR) && !open_vec[bank_i]) |=> err_o);

   assert_nop_no_err_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_i == CMD_NOP) |=> !err_o);

   assert_act_open_err_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_i == CMD_ACT && open_vec[bank_i]) |=> (err_o && open_vec[$past(bank_i)]));

   assert_pre_closes_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_i == CMD_PRE && !(eng_busy && eng_bank == bank_i)) |=> !open_vec[$past(bank_i)]);

   assert_busy_reject_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (eng_busy && (cmd_i == CMD_RD || cmd_i == CMD_WR || cmd_i == CMD_MODE)) |=> err_o);
endmodule

bind dual_bank_burst_ram dual_bank_burst_ram_chk #(
   .NUM_BANKS (NUM_BANKS),
   .DATA_W    (DATA_W)
) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .cmd_i      (cmd_i),
   .bank_i     (bank_i),
   .rd_data_o  (rd_data_o),
   .rd_valid_o (rd_valid_o),
   .err_o      (err_o),
   .open_vec   (bank_open),
   .eng_busy   (eng_busy),
   .eng_bank   (eng_bank)
);

// File: tb/dual_bank_burst_ram_bench.sv
module dual_bank_burst_ram_bench;
   localparam int ROW_W  = 3;
   localparam int COL_W  = 4;
   localparam int BANK_WORDS = 1 << (ROW_W + COL_W);
   localparam int RING = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  cmd = 3'd0;
   logic [0:0]  bank = 1'b0;
   logic [3:0]  addr = 4'd0;
   logic [15:0] wdata = 16'd0;
   logic [15:0] rd_data;
   logic        rd_valid;
   logic        err;

   always #2 clk = ~clk;

   dual_bank_burst_ram u_dual_bank_burst_ram (
      .clk_i(clk), .rst_ni(rst_n), .cmd_i(cmd), .bank_i(bank), .addr_i(addr),
      .wr_data_i(wdata), .rd_data_o(rd_data), .rd_valid_o(rd_valid), .err_o(err)
   );

   int checks = 0;
   int fails = 0;
   int cyc = 0;
   bit done = 0;

   // reference model state
   logic [15:0] ref_mem [2*BANK_WORDS];
   bit          m_open [2];
   int          m_row [2];
   int          m_bl = 1;
   int          m_lat = 2;
   int          busy_end = 0;
   int          bsy_bank = 0;
   int          wr_start = -1, wr_end = -1, wr_bank = 0, wr_row = 0, wr_base = 0, wr_bl = 1;
   string       cur_tag = "R1";

   bit          exp_v [RING];
   logic [15:0] exp_d [RING];
   bit          exp_e [RING];
   string       exp_t [RING];

   function automatic int colf(int base, int i, int bl);
      return ((base & ~(bl - 1)) | ((base + i) & (bl - 1))) & 15;
   endfunction

   function automatic int midx(int b, int r, int c);
      return b * BANK_WORDS + r * 16 + c;
   endfunction

   task automatic sched_err(string tag);
      int s = (cyc + 1) % RING;
      exp_e[s] = 1'b1;
      exp_t[s] = tag;
   endtask

   task automatic check_now();
      int s = cyc % RING;
      checks++;
      if (rd_valid !== exp_v[s] || rd_data !== exp_d[s] || err !== exp_e[s]) begin
         fails++;
         $display("FAIL %s cycle %0d: valid/data/err = %0b/%h/%0b expected %0b/%h/%0b",
                  exp_t[s], cyc, rd_valid, rd_data, err, exp_v[s], exp_d[s], exp_e[s]);
      end
      exp_v[s] = 1'b0; exp_d[s] = 16'd0; exp_e[s] = 1'b0; exp_t[s] = "R3";
   endtask

   task automatic model(int c_cmd, int b, int a, logic [15:0] wd);
      bit busy = (cyc < busy_end);
      if (cyc > wr_start && cyc < wr_end)
         ref_mem[midx(wr_bank, wr_row, colf(wr_base, cyc - wr_start, wr_bl))] = wd;
      case (c_cmd)
         1: if (busy) sched_err("R9");
            else begin m_bl = 1 << (a & 3); m_lat = (a & 4) ? 3 : 2; end
         2: if (m_open[b]) sched_err("R8");
            else begin m_open[b] = 1'b1; m_row[b] = a & 7; end
         5: if (busy && bsy_bank == b) sched_err("R9");
            else m_open[b] = 1'b0;
         3, 4: begin
            if (busy) sched_err("R9");
            else if (!m_open[b]) sched_err("R7");
            else if (c_cmd == 4) begin
               ref_mem[midx(b, m_row[b], a & 15)] = wd;
               wr_start = cyc; wr_end = cyc + m_bl; wr_bank = b;
               wr_row = m_row[b]; wr_base = a & 15; wr_bl = m_bl;
               busy_end = cyc + m_bl; bsy_bank = b;
            end else begin
               for (int i = 0; i < m_bl; i++) begin
                  int s = (cyc + m_lat + i) % RING;
                  exp_v[s] = 1'b1;
                  exp_d[s] = ref_mem[midx(b, m_row[b], colf(a & 15, i, m_bl))];
                  exp_t[s] = cur_tag;
               end
               busy_end = cyc + m_lat + m_bl - 1; bsy_bank = b;
            end
         end
         default: ;
      endcase
   endtask

   task automatic step(int c_cmd, int b, int a, logic [15:0] wd);
      check_now();
      model(c_cmd, b, a, wd);
      cmd = 3'(c_cmd); bank = 1'(b); addr = 4'(a); wdata = wd;
      @(negedge clk);
      cyc++;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) step(0, 0, 0, 16'h0);
   endtask

   task automatic wr_burst(int b, int col, int n, logic [15:0] seed);
      step(4, b, col, seed);
      for (int i = 1; i < n; i++) step(0, 0, 0, seed + 16'(i * 17));
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: run did not finish, actual hung expected done");
         summary();
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      for (int s = 0; s < RING; s++) begin
         exp_v[s] = 0; exp_d[s] = 0; exp_e[s] = 0; exp_t[s] = "R3";
      end
      for (int i = 0; i < 2 * BANK_WORDS; i++) ref_mem[i] = 16'd0;
      m_open[0] = 0; m_open[1] = 0; m_row[0] = 0; m_row[1] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset outputs, default burst 1 and latency 2
      cur_tag = "R1";
      step(0, 0, 0, 0);
      step(2, 0, 2, 0);
      step(4, 0, 5, 16'hA5A5);
      step(3, 0, 5, 0);
      idle(4);
      step(5, 0, 0, 0);

      // prefill every cell through 8-word bursts (R5)
      cur_tag = "R5";
      step(1, 0, 3, 0);
      for (int b = 0; b < 2; b++)
         for (int r = 0; r < 8; r++) begin
            step(2, b, r, 0);
            wr_burst(b, 0, 8, 16'(b * 4096 + r * 256 + 1));
            wr_burst(b, 8, 8, 16'(b * 4096 + r * 256 + 129));
            step(5, b, 0, 0);
         end

      // R2: mode operand with ignored upper bit -> length 4, latency 3
      cur_tag = "R2";
      step(1, 0, 4'b1110, 0);
      step(2, 0, 4, 0);
      // R4: start column 6 wraps to 6,7,4,5
      cur_tag = "R4";
      step(3, 0, 6, 0);
      idle(7);
      // R5: write burst at column 9 then read back 9,10,11,8
      cur_tag = "R5";
      wr_burst(0, 9, 4, 16'hBEE0);
      step(3, 0, 9, 0);
      idle(7);

      // R6: both banks open, accesses use each bank's own row
      cur_tag = "R6";
      step(1, 0, 3, 0);
      step(2, 1, 6, 0);
      step(3, 1, 3, 0);
      idle(9);
      step(3, 0, 2, 0);
      idle(9);

      // R9: during a burst of bank 0, prepare bank 1; blocked commands err
      cur_tag = "R9";
      step(3, 0, 0, 0);
      step(5, 1, 0, 0);
      step(2, 1, 1, 0);
      step(3, 1, 0, 0);
      step(5, 0, 0, 0);
      step(1, 0, 0, 0);
      step(4, 1, 0, 16'h1234);
      idle(5);
      step(3, 1, 4, 0);
      idle(9);

      // R7: closed bank access and idle command
      cur_tag = "R7";
      step(5, 0, 0, 0);
      step(3, 0, 1, 0);
      step(4, 0, 1, 16'hDEAD);
      step(0, 0, 0, 0);
      step(2, 0, 1, 0);
      step(3, 0, 0, 0);
      idle(9);

      // R8: activate to open bank keeps old row; double precharge is silent
      cur_tag = "R8";
      step(2, 1, 5, 0);
      step(3, 1, 12, 0);
      idle(9);
      step(5, 1, 0, 0);
      step(5, 1, 0, 0);
      step(2, 1, 7, 0);
      step(3, 1, 15, 0);
      idle(9);

      // R3: random mix of commands, modes and data
      cur_tag = "R3";
      for (int n = 0; n < 3000; n++) begin
         int r = int'($urandom % 100);
         int c;
         if (r < 30)      c = 0;
         else if (r < 45) c = 2;
         else if (r < 58) c = 5;
         else if (r < 76) c = 3;
         else if (r < 93) c = 4;
         else             c = 1;
         step(c, int'($urandom % 2), int'($urandom % 16), 16'($urandom));
      end
      idle(12);

      done = 1;
      summary();
      $finish;
   end
endmodule